// File: doc/BRIEF.md
# Shared-Pin Analog Input Mux and SAR Conversion Controller

This block decides which of eight shared general-purpose pins act as analog channels and runs the successive-approximation conversion for the selected channel. A 3-bit pin-configuration code picks the set of analog pins. On those pins it forces the effective direction to input and turns off the pull-up, whatever the port registers hold. Digital pins pass their direction and pull-up settings through unchanged. The code can be rewritten at any time, so pins can move between digital and analog use in either direction.

Conversions are timed by a conversion clock. A 2-bit select sets that clock to the system clock divided by 4, 6, 8 or 12. Software controls conversions through a level START bit and reads an active-low end-of-conversion flag. The sequencer drives a 10-bit DAC trial code and samples an external comparator bit once per conversion-clock period.

Writing the pin configuration or the channel number leaves the flag in an unusable state. A short START pulse must then restore the flag before it can be trusted.

Top module: `adc_pinmux_ctrl`

## Requirements
- R1: The analog pin mask follows the configuration code: 000→none, 001→pin 0, 010→pins 0-1, 011→pins 0-2, 100→pins 1-3 with pin 0 left digital, 101 and 110→pins 0-5, 111→all eight. `pin_analog` shows the mask two clock edges after the write.
- R2: The effective direction (`pin_dir`, 1 = input) is 1 on every analog pin. On a digital pin it equals the `port_dir` bit. It is registered, with one edge of latency.
- R3: The effective pull-up (`pin_pullup`) is 0 on every analog pin. On a digital pin it equals the `port_pu` bit. It is registered, with one edge of latency.
- R4: The conversion-clock period is 4, 6, 8 or 12 system clocks for select codes 00, 01, 10 and 11. A conversion takes exactly 10 periods, so `eoc_n` goes low 10×ratio edges after the edge that sees START fall.
- R5: A write to the clock select reloads the divider at once. The steps still to run each take the new ratio in full, and no partial old-ratio period occurs.
- R6: While a re-initialise is pending, a START pulse high for 1 to 10 edges only drives `eoc_n` high and clears the pending state. No conversion runs and `dac_code` stays 0.
- R7: Any write to the pin configuration or the channel number drives `eoc_n` low on the next edge. This is a spurious done signal, and the re-initialise is then pending. A conversion in flight is abandoned.
- R8: A START pulse high for 11 or more edges always starts a conversion. A pulse of any length starts one when no re-initialise is pending.
- R9: With a comparator that reports (input ≥ `dac_code`), the loaded `result` equals the 10-bit input value.
- R10: If the selected channel is not analog when the conversion starts, the conversion still runs its full length, `result` is 0 and `chan_bad` is 1. For a valid channel, `chan_bad` is 0.
- R11: `eoc_n` stays high while a conversion runs. `result` changes only on the edge that drives `eoc_n` low.
- R12: After reset: `eoc_n`=1, `result`=0, `chan_bad`=0, `dac_code`=0, no analog pins, all effective directions input, all pull-ups off, clock select 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the pin-configuration code |
| cfg_wdata | input | 3 | Pin-configuration code |
| chan_we | input | 1 | Write strobe for the channel number |
| chan_wdata | input | 3 | Channel to convert |
| clksel_we | input | 1 | Write strobe for the clock select |
| clksel_wdata | input | 2 | Conversion-clock divider select |
| start | input | 1 | START control bit (level) |
| port_dir | input | 8 | Port direction register, 1 = input |
| port_pu | input | 8 | Port pull-up enables |
| cmp_in | input | 1 | Comparator: 1 when input ≥ DAC level |
| pin_analog | output | 8 | Pins in analog use |
| pin_dir | output | 8 | Effective direction, 1 = input |
| pin_pullup | output | 8 | Effective pull-up enables |
| dac_code | output | 10 | SAR trial code, 0 when idle |
| result | output | 10 | Last conversion result |
| eoc_n | output | 1 | End of conversion, active low |
| chan_bad | output | 1 | Last conversion used a non-analog channel |

## Verification
Code 100 is exercised directly. A map that treated it as a plain prefix would leave pin 0 analog or pin 3 digital. START pulses of exactly 10 and 11 edges are driven while a re-initialise is pending. An off-by-one pulse classifier would either start a conversion where only the flag should recover, or leave the flag stuck. A clock-select write lands partway through a conversion. If the divider were not reloaded, the total conversion time would be off by the leftover old-ratio count. Random channels, codes, ratios and input values then check the conversion length, the result, and zero returned on non-analog channels.

// File: rtl/adc_mux_pkg.sv
package adc_mux_pkg;

  localparam int PIN_W = 8;

  // analog pin mask for each configuration code
  function automatic logic [PIN_W-1:0] analog_map(input logic [2:0] code);
    logic [PIN_W-1:0] m;
    case (code)
      3'd0:    m = 8'h00;
      3'd1:    m = 8'h01;
      3'd2:    m = 8'h03;
      3'd3:    m = 8'h07;
      3'd4:    m = 8'h0E;
      3'd5,
      3'd6:    m = 8'h3F;
      default: m = 8'hFF;
    endcase
    return m;
  endfunction

  // conversion-clock ratio for each select code
  function automatic logic [3:0] div_ratio(input logic [1:0] sel);
    logic [3:0] r;
    case (sel)
      2'd0:    r = 4'd4;
      2'd1:    r = 4'd6;
      2'd2:    r = 4'd8;
      default: r = 4'd12;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/adc_pin_mux.sv
module adc_pin_mux
  import adc_mux_pkg::*;
#(
  parameter int NPINS = PIN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] amask,
  input  logic [NPINS-1:0] dir_in,
  input  logic [NPINS-1:0] pu_in,
  output logic [NPINS-1:0] analog_q,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] pu_q
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        analog_q[i] <= 1'b0;
        dir_q[i]    <= 1'b1;
        pu_q[i]     <= 1'b0;
      end else begin
        analog_q[i] <= amask[i];
        dir_q[i]    <= amask[i] | dir_in[i];
        pu_q[i]     <= ~amask[i] & pu_in[i];
      end
    end
  end

endmodule

// File: rtl/adc_clk_div.sv
module adc_clk_div
  import adc_mux_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel,
  input  logic       reload,
  output logic       tick
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last = CNT_W'(div_ratio(sel)) - CNT_W'(1);
  assign tick = (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || reload) cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + CNT_W'(1);
  end

endmodule

// File: rtl/adc_start_ctl.sv
module adc_start_ctl #(
  parameter int REINIT_MAX = 10,
  localparam int HCNT_W    = $clog2(REINIT_MAX + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic fall,
  output logic short_pulse
);

  logic              start_q;
  logic [HCNT_W-1:0] hi_cnt;

  assign fall        = start_q & ~start;
  assign short_pulse = (hi_cnt <= HCNT_W'(REINIT_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      hi_cnt  <= '0;
    end else begin
      start_q <= start;
      if (start) begin
        if (!start_q)      hi_cnt <= HCNT_W'(1);
        else if (!(&hi_cnt)) hi_cnt <= hi_cnt + HCNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq #(
  parameter int RES_W  = 10,
  localparam int IDX_W = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             fall,
  input  logic             short_pulse,
  input  logic             cfg_write,
  input  logic             chan_ok,
  input  logic             cmp_in,
  output logic             launch,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result,
  output logic             eoc_n,
  output logic             chan_bad
);

  logic             conv_q;
  logic             pending_q;
  logic             ok_q;
  logic [IDX_W-1:0] bit_idx;
  logic [RES_W-1:0] onehot;
  logic [RES_W-1:0] keep;
  logic             reinit;
  logic             idle_fall;

  assign idle_fall = fall & ~conv_q & ~cfg_write;
  assign reinit    = idle_fall & pending_q & short_pulse;
  assign launch    = idle_fall & ~(pending_q & short_pulse);

  always_comb begin
    onehot = RES_W'(1) << bit_idx;
    keep   = cmp_in ? dac_code : (dac_code & ~onehot);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_q    <= 1'b0;
      pending_q <= 1'b0;
      ok_q      <= 1'b0;
      bit_idx   <= '0;
      dac_code  <= '0;
      result    <= '0;
      eoc_n     <= 1'b1;
      chan_bad  <= 1'b0;
    end else if (cfg_write) begin
      conv_q    <= 1'b0;
      dac_code  <= '0;
      pending_q <= 1'b1;
      eoc_n     <= 1'b0;
    end else if (conv_q) begin
      if (tick) begin
        if (bit_idx == '0) begin
          result   <= ok_q ? keep : '0;
          chan_bad <= ~ok_q;
          eoc_n    <= 1'b0;
          conv_q   <= 1'b0;
          dac_code <= '0;
        end else begin
          dac_code <= keep | (onehot >> 1);
          bit_idx  <= bit_idx - IDX_W'(1);
        end
      end
    end else if (reinit) begin
      eoc_n     <= 1'b1;
      pending_q <= 1'b0;
    end else if (launch) begin
      conv_q    <= 1'b1;
      bit_idx   <= IDX_W'(RES_W - 1);
      dac_code  <= RES_W'(1) << (RES_W - 1);
      ok_q      <= chan_ok;
      eoc_n     <= 1'b1;
      pending_q <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_pinmux_ctrl.sv
module adc_pinmux_ctrl
  import adc_mux_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int REINIT_MAX = 10,
  parameter int DIV_CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_wdata,
  input  logic             chan_we,
  input  logic [2:0]       chan_wdata,
  input  logic             clksel_we,
  input  logic [1:0]       clksel_wdata,
  input  logic             start,
  input  logic [PIN_W-1:0] port_dir,
  input  logic [PIN_W-1:0] port_pu,
  input  logic             cmp_in,
  output logic [PIN_W-1:0] pin_analog,
  output logic [PIN_W-1:0] pin_dir,
  output logic [PIN_W-1:0] pin_pullup,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result,
  output logic             eoc_n,
  output logic             chan_bad
);

  logic [2:0]       cfg_q;
  logic [2:0]       chan_q;
  logic [1:0]       clksel_q;
  logic [PIN_W-1:0] amask;
  logic             tick, fall, short_pulse, launch;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      chan_q   <= '0;
      clksel_q <= '0;
    end else begin
      if (cfg_we)    cfg_q    <= cfg_wdata;
      if (chan_we)   chan_q   <= chan_wdata;
      if (clksel_we) clksel_q <= clksel_wdata;
    end
  end

  assign amask = analog_map(cfg_q);

  adc_pin_mux #(.NPINS(PIN_W)) u_pins (
    .clk(clk), .rst(rst), .amask(amask), .dir_in(port_dir), .pu_in(port_pu),
    .analog_q(pin_analog), .dir_q(pin_dir), .pu_q(pin_pullup)
  );

  adc_clk_div #(.CNT_W(DIV_CNT_W)) u_div (
    .clk(clk), .rst(rst), .sel(clksel_q), .reload(clksel_we | launch), .tick(tick)
  );

  adc_start_ctl #(.REINIT_MAX(REINIT_MAX)) u_start (
    .clk(clk), .rst(rst), .start(start), .fall(fall), .short_pulse(short_pulse)
  );

  adc_sar_seq #(.RES_W(RES_W)) u_sar (
    .clk(clk), .rst(rst), .tick(tick), .fall(fall), .short_pulse(short_pulse),
    .cfg_write(cfg_we | chan_we), .chan_ok(amask[chan_q]), .cmp_in(cmp_in),
    .launch(launch), .dac_code(dac_code), .result(result), .eoc_n(eoc_n),
    .chan_bad(chan_bad)
  );

endmodule

// File: rtl/adc_pinmux_ctrl_chk.sv
module adc_pinmux_ctrl_chk #(
  parameter int RES_W = 10,
  parameter int NP    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic             chan_we,
  input logic [NP-1:0]    pin_analog,
  input logic [NP-1:0]    pin_dir,
  input logic [NP-1:0]    pin_pullup,
  input logic [RES_W-1:0] dac_code,
  input logic [RES_W-1:0] result,
  input logic             eoc_n,
  input logic             chan_bad
);

  p_mask_legal_r1: assert property (@(posedge clk) disable iff (rst)
    pin_analog inside {8'h00, 8'h01, 8'h03, 8'h07, 8'h0E, 8'h3F, 8'hFF});

  p_analog_input_r2: assert property (@(posedge clk) disable iff (rst)
    (pin_analog & ~pin_dir) == '0);

  p_analog_nopull_r3: assert property (@(posedge clk) disable iff (rst)
    (pin_analog & pin_pullup) == '0);

  p_write_invalid_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_we | chan_we)) |-> !eoc_n);

  p_bad_zero_r10: assert property (@(posedge clk) disable iff (rst)
    chan_bad |-> (result == '0));

  p_busy_flag_r11: assert property (@(posedge clk) disable iff (rst)
    (dac_code != '0) |-> eoc_n);

  p_result_on_done_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> !eoc_n);

endmodule

bind adc_pinmux_ctrl adc_pinmux_ctrl_chk #(.RES_W(RES_W), .NP(8)) u_chk (.*);

// File: tb/adc_pinmux_ctrl_bench.sv
module adc_pinmux_ctrl_bench;

  logic       clk = 0;
  logic       rst = 1;
  logic       cfg_we = 0, chan_we = 0, clksel_we = 0, start = 0;
  logic [2:0] cfg_wdata = 0, chan_wdata = 0;
  logic [1:0] clksel_wdata = 0;
  logic [7:0] port_dir = 0, port_pu = 0;
  logic [9:0] vin = 0;
  logic       cmp_in;
  logic [7:0] pin_analog, pin_dir, pin_pullup;
  logic [9:0] dac_code, result;
  logic       eoc_n, chan_bad;

  int checks = 0, errors = 0;
  logic [2:0] cur_cfg = 0, cur_chan = 0;
  logic [1:0] cur_sel = 0;

  always #2.5 clk = ~clk;

  assign cmp_in = (vin >= dac_code);

  adc_pinmux_ctrl u_adc_pinmux_ctrl (.*);

  function automatic logic [7:0] exp_mask(input logic [2:0] c);
    case (c)
      3'd0: return 8'b0000_0000;
      3'd1: return 8'b0000_0001;
      3'd2: return 8'b0000_0011;
      3'd3: return 8'b0000_0111;
      3'd4: return 8'b0000_1110;
      3'd5, 3'd6: return 8'b0011_1111;
      default: return 8'b1111_1111;
    endcase
  endfunction

  function automatic int exp_ratio(input logic [1:0] s);
    case (s)
      2'd0: return 4;
      2'd1: return 6;
      2'd2: return 8;
      default: return 12;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic write_cfg(input logic [2:0] c);
    @(negedge clk); cfg_we = 1; cfg_wdata = c;
    @(posedge clk); #1 cfg_we = 0; cur_cfg = c;
  endtask

  task automatic write_chan(input logic [2:0] c);
    @(negedge clk); chan_we = 1; chan_wdata = c;
    @(posedge clk); #1 chan_we = 0; cur_chan = c;
  endtask

  task automatic write_sel(input logic [1:0] s);
    @(negedge clk); clksel_we = 1; clksel_wdata = s;
    @(posedge clk); #1 clksel_we = 0; cur_sel = s;
  endtask

  // START high for n edges, then low; returns just after the fall-detect edge
  task automatic pulse(input int n);
    @(negedge clk); start = 1;
    repeat (n) @(posedge clk);
    @(negedge clk); start = 0;
    @(posedge clk);
  endtask

  task automatic wait_done(input int k0, output int k);
    k = k0;
    forever begin
      @(negedge clk);
      if (!eoc_n || k > 3000) break;
      @(posedge clk); k++;
    end
  endtask

  task automatic check_pins(input string tag);
    logic [7:0] m;
    m = exp_mask(cur_cfg);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(pin_analog == m, "R1", {tag, " analog mask"}, pin_analog, m);
    chk(pin_dir == (m | port_dir), "R2", {tag, " dir"}, pin_dir, m | port_dir);
    chk(pin_pullup == (~m & port_pu), "R3", {tag, " pullup"}, pin_pullup, ~m & port_pu);
  endtask

  // run a conversion from a START pulse of n edges and check it
  task automatic conv(input int n, input string req);
    int k, expk;
    logic bad;
    logic [9:0] er;
    bad  = !exp_mask(cur_cfg)[cur_chan];
    er   = bad ? 10'd0 : vin;
    expk = 10 * exp_ratio(cur_sel);
    pulse(n);
    wait_done(0, k);
    chk(k == expk, "R4", {req, " conversion length"}, k, expk);
    chk(result == er, bad ? "R10" : "R9", {req, " result"}, result, er);
    chk(chan_bad == bad, "R10", {req, " chan_bad"}, chan_bad, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int k;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    chk(eoc_n == 1, "R12", "eoc_n", eoc_n, 1);
    chk(result == 0, "R12", "result", result, 0);
    chk(chan_bad == 0, "R12", "chan_bad", chan_bad, 0);
    chk(dac_code == 0, "R12", "dac_code", dac_code, 0);
    chk(pin_analog == 0, "R12", "pin_analog", pin_analog, 0);
    chk(pin_dir == 8'hFF, "R12", "pin_dir", pin_dir, 8'hFF);
    chk(pin_pullup == 0, "R12", "pin_pullup", pin_pullup, 0);
    rst = 0;

    // R1 R2 R3: every configuration code, including code 100
    for (int c = 0; c < 8; c++) begin
      port_dir = 8'h00; port_pu = 8'hFF;
      write_cfg(3'(c));
      check_pins("all-out");
      port_dir = 8'($urandom); port_pu = 8'($urandom);
      check_pins("random");
    end

    // R7: write makes the flag falsely low
    write_cfg(3'd7);
    @(negedge clk);
    chk(eoc_n == 0, "R7", "eoc_n after cfg write", eoc_n, 0);
    // R6: short pulse restores flag, no conversion
    pulse(3);
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk(eoc_n == 1, "R6", "eoc_n after 3-edge pulse", eoc_n, 1);
    chk(dac_code == 0, "R6", "dac idle after reinit", dac_code, 0);
    chk(result == 0, "R6", "result untouched", result, 0);

    // R6 boundary: 10 edges is still a re-initialise
    write_chan(3'd5);
    @(negedge clk);
    chk(eoc_n == 0, "R7", "eoc_n after chan write", eoc_n, 0);
    pulse(10);
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk(eoc_n == 1 && dac_code == 0, "R6", "10-edge pulse reinit only", eoc_n, 1);

    // R8 boundary: 11 edges while pending converts
    write_chan(3'd5);
    vin = 10'd693;
    conv(11, "R8 11-edge pending");
    // R8: short pulse with nothing pending converts
    vin = 10'd1023;
    conv(3, "R8 short not pending");
    vin = 10'd0;
    conv(12, "R9 zero input");

    // R5: clock-select write partway through a conversion
    vin = 10'd300;
    pulse(12);
    repeat (4) @(posedge clk);
    @(negedge clk); clksel_we = 1; clksel_wdata = 2'd3;
    @(posedge clk); #1 clksel_we = 0; cur_sel = 2'd3;
    wait_done(5, k);
    chk(k == 113, "R5", "length with mid-conversion reload", k, 113);
    chk(result == 10'd300, "R5", "result after reload", result, 300);

    // R10: channel not analog
    write_cfg(3'd1); write_chan(3'd3);
    vin = 10'd512;
    pulse(2);
    conv(15, "R10 non-analog channel");
    // R7: write during conversion abandons it
    write_cfg(3'd7);
    pulse(15);
    repeat (5) @(posedge clk);
    write_chan(3'd2);
    @(negedge clk);
    chk(eoc_n == 0 && dac_code == 0, "R7", "abandon in flight", dac_code, 0);
    pulse(2);

    // random mix
    for (int i = 0; i < 16; i++) begin
      write_cfg(3'($urandom));
      write_chan(3'($urandom));
      write_sel(2'(i % 4));
      port_dir = 8'($urandom); port_pu = 8'($urandom);
      check_pins("rand");
      pulse(1 + ($urandom % 10));
      @(negedge clk);
      chk(eoc_n == 1, "R6", "rand reinit", eoc_n, 1);
      vin = 10'($urandom);
      conv(11 + ($urandom % 5), "R11 rand");
    end

    summary();
  end

endmodule